// File: doc/BRIEF.md
# Dual-Bank On-Chip RAM Controller

This block is a single-port on-chip memory built from two equal banks behind one synchronous request bus. One address bit steers each access to the low or the high bank. A read or a write is taken in the cycle the request is presented. A read result and the error flag come from registers, so they appear on the clock edge that follows the request. Bits above the bank-select bit must be zero, otherwise the access is out of range.

Power management is seen from the memory side. A global enable input gates every access. Two stop inputs freeze one bank each. Freezing a bank keeps its contents, but no access reaches it while it is stopped. A deep-standby input marks a low-power period. On entry, the high bank always loses its data. The low bank loses its data unless the retention-select input is high at the entry edge. Lost words read as the pattern 0xDEADBEEF until they are written again, so data loss can be seen.

The bank size is a parameter. Fourteen word-address bits per bank give 64 KiB per bank, with bank 0 at 0x0000_0000–0x0000_FFFF and bank 1 at 0x0001_0000–0x0001_FFFF. The default is smaller, to keep elaboration light.

Top module: `ram_dual_bank`

## Requirements
- R1: The byte address is decoded as follows. Bits [1:0] are ignored. The word index is bits [BANK_WAW+1:2]. Bit BANK_WAW+2 selects the bank (0 = low, 1 = high). Any nonzero bit from BANK_WAW+3 upward makes the request an out-of-range error.
- R2: A request presented in cycle N has its result on rdata_o/err_o after the clock edge that ends cycle N. A write is visible to a read issued in the very next cycle.
- R3: While ram_en_i is low, every request fails and memory is not changed.
- R4: While stop bit b (stop_i[b], bit 0 = low bank, bit 1 = high bank) is in force, requests to bank b fail. The other bank keeps working. Bank b keeps its contents through the stop.
- R5: Synchronous active-low reset has these effects: both stop bits count as clear, rdata_o = 0, err_o = 0, and every word reads as 0xDEADBEEF until written.
- R6: A request accepted in the same cycle that a stop bit rises is still serviced. The stop blocks requests from the next cycle onward.
- R7: A failed request produces err_o = 1 and rdata_o = 0 for one cycle per request, and it leaves memory unchanged.
- R8: Byte strobe be_i[k] enables write data bits [8k+7:8k]. Bytes whose strobe is low keep their previous value.
- R9: A word that has not been written since reset or since being lost reads 0xDEADBEEF. On a partial write to such a word, the unstrobed bytes take their bytes from 0xDEADBEEF.
- R10: While standby_i is high, every request fails. On the rising edge of standby_i, all high-bank words are lost. Low-bank words are lost unless retain_i is high in that cycle.
- R11: A cycle with no request, and a successful write, produce rdata_o = 0 and err_o = 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ram_en_i | input | 1 | Global RAM enable |
| stop_i | input | 2 | Per-bank stop bits (bit 0 low bank, bit 1 high bank) |
| standby_i | input | 1 | Deep-standby indication, high while in standby |
| retain_i | input | 1 | Keep low-bank contents across standby entry |
| req_i | input | 1 | Access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | ADDR_W | Byte address |
| be_i | input | 4 | Byte strobes for writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | Registered error flag |

## Verification
The bench builds the block with BANK_WAW = 3, which gives eight words per bank. With that size, every word of both banks is tracked by the reference model through poisoning, retention and rewrite. The bank-select bit then sits at address bit 5 and the first out-of-range bit at bit 6. As a result, both the bank boundary and the range boundary are reached with small addresses next to valid ones. The stop-bit timing and the standby entry are driven on exact cycles, so the one-cycle grace of a rising stop bit and the choice between retaining and losing the low bank are both observed.

// File: rtl/ram_db_pkg.sv
// Shared constants and helpers for the dual-bank RAM.
// Assumes a fixed 32-bit data path with four byte lanes.
package ram_db_pkg;
    localparam int          NUM_BANKS   = 2;
    localparam int          DATA_W      = 32;
    localparam int          LANES       = DATA_W / 8;
    localparam logic [31:0] POISON_WORD = 32'hDEADBEEF;
    // Bank b survives standby only if this bit is set and retention is chosen.
    localparam logic [NUM_BANKS-1:0] RETAIN_MASK = 2'b01;

    // Replace the strobed byte lanes of base with those of data.
    function automatic logic [DATA_W-1:0] merge_lanes(
        input logic [DATA_W-1:0] base,
        input logic [DATA_W-1:0] data,
        input logic [LANES-1:0]  be
    );
        logic [DATA_W-1:0] res;
        res = base;
        for (int k = 0; k < LANES; k++) begin
            if (be[k]) res[8*k +: 8] = data[8*k +: 8];
        end
        return res;
    endfunction
endpackage

// File: rtl/ram_db_decode.sv
// Address decoder and access gate.
// Splits a byte address into bank and word index and decides whether
// the request may proceed. The request is blocked by the global enable,
// by standby, by an out-of-range address, or by the registered stop bit
// of the target bank. Purely combinational.
module ram_db_decode
    import ram_db_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int BANK_WAW = 8
) (
    input  logic                 req_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 en_i,
    input  logic                 standby_i,
    input  logic [NUM_BANKS-1:0] stop_q_i,
    output logic [NUM_BANKS-1:0] sel_o,
    output logic [BANK_WAW-1:0]  idx_o,
    output logic                 fail_o
);
    localparam int SEL_BIT = BANK_WAW + 2;
    localparam int HI_LSB  = SEL_BIT + 1;

    logic in_range;
    logic bank;
    logic open_gate;
    logic unused_byte_ofs;

    assign unused_byte_ofs = ^addr_i[1:0];
    assign in_range  = (addr_i[ADDR_W-1:HI_LSB] == '0);
    assign bank      = addr_i[SEL_BIT];
    assign idx_o     = addr_i[SEL_BIT-1:2];
    assign open_gate = en_i & ~standby_i & in_range & ~stop_q_i[bank];
    assign fail_o    = req_i & ~open_gate;

    // One select line per bank.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
        assign sel_o[b] = req_i & open_gate & (bank == 1'(b));
    end
endmodule

// File: rtl/ram_db_bank.sv
// One storage bank with per-word liveness.
// A word whose live bit is clear reads as the poison pattern. A write
// merges the strobed lanes into the current (possibly poison) value and
// marks the word live. wipe_i clears every live bit in one cycle.
// Read data is combinational; the top registers it.
module ram_db_bank
    import ram_db_pkg::*;
#(
    parameter int BANK_WAW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_i,
    input  logic                we_i,
    input  logic [LANES-1:0]    be_i,
    input  logic [BANK_WAW-1:0] idx_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic                wipe_i,
    output logic [DATA_W-1:0]   rd_o
);
    localparam int DEPTH = 1 << BANK_WAW;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]  live;
    logic [DATA_W-1:0] cur;

    assign cur  = live[idx_i] ? mem[idx_i] : POISON_WORD;
    assign rd_o = cur;

    // Storage array write port.
    always_ff @(posedge clk) begin
        if (acc_i && we_i) mem[idx_i] <= merge_lanes(cur, wdata_i, be_i);
    end

    // Liveness tracking: cleared by reset or wipe, set by a write.
    always_ff @(posedge clk) begin
        if (!rst_n)             live        <= '0;
        else if (wipe_i)        live        <= '0;
        else if (acc_i && we_i) live[idx_i] <= 1'b1;
    end
endmodule

// File: rtl/ram_dual_bank.sv
// Dual-bank on-chip RAM controller (top).
// Registers the stop bits so that a stop rising with a request takes
// effect one cycle later. Detects standby entry to wipe the banks that
// lose power. Registers the read data and error flag.
// Assumes software does not raise a stop bit mid-transfer; a single-cycle
// bus makes that the same-cycle case.
module ram_dual_bank
    import ram_db_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int BANK_WAW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ram_en_i,
    input  logic [NUM_BANKS-1:0] stop_i,
    input  logic                 standby_i,
    input  logic                 retain_i,
    input  logic                 req_i,
    input  logic                 we_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [LANES-1:0]     be_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [DATA_W-1:0]    rdata_o,
    output logic                 err_o
);
    logic [NUM_BANKS-1:0] stop_q;
    logic                 standby_q;
    logic                 entering;
    logic [NUM_BANKS-1:0] sel;
    logic [NUM_BANKS-1:0] wipe;
    logic [BANK_WAW-1:0]  idx;
    logic                 fail;
    logic [DATA_W-1:0]    bank_rd [NUM_BANKS];
    logic [DATA_W-1:0]    rd_pick;

    // Delay stop and standby by one cycle for grace and edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q    <= '0;
            standby_q <= 1'b0;
        end else begin
            stop_q    <= stop_i;
            standby_q <= standby_i;
        end
    end

    assign entering = standby_i & ~standby_q;

    ram_db_decode #(
        .ADDR_W   (ADDR_W),
        .BANK_WAW (BANK_WAW)
    ) u_decode (
        .req_i     (req_i),
        .addr_i    (addr_i),
        .en_i      (ram_en_i),
        .standby_i (standby_i),
        .stop_q_i  (stop_q),
        .sel_o     (sel),
        .idx_o     (idx),
        .fail_o    (fail)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign wipe[b] = entering & (RETAIN_MASK[b] ? ~retain_i : 1'b1);

        ram_db_bank #(
            .BANK_WAW (BANK_WAW)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .acc_i   (sel[b]),
            .we_i    (we_i),
            .be_i    (be_i),
            .idx_i   (idx),
            .wdata_i (wdata_i),
            .wipe_i  (wipe[b]),
            .rd_o    (bank_rd[b])
        );
    end

    // Pick the word of the selected bank; zero when none is selected.
    always_comb begin
        rd_pick = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (sel[b]) rd_pick = bank_rd[b];
        end
    end

    // Output registers: read data only for a successful read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o <= '0;
            err_o   <= 1'b0;
        end else begin
            rdata_o <= we_i ? '0 : rd_pick;
            err_o   <= fail;
        end
    end
endmodule

// File: rtl/ram_dual_bank_chk.sv
// Port-level protocol checker for ram_dual_bank, bound to every instance.
// Assumes a synchronous active-low reset.
module ram_dual_bank_chk #(
    parameter int ADDR_W   = 32,
    parameter int BANK_WAW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ram_en_i,
    input logic [1:0]        stop_i,
    input logic              standby_i,
    input logic              req_i,
    input logic              we_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [31:0]       rdata_o,
    input logic              err_o
);
    localparam int SEL_BIT = BANK_WAW + 2;
    localparam int HI_LSB  = SEL_BIT + 1;

    logic armed;
    logic unused_lo;

    assign unused_lo = ^addr_i[SEL_BIT-1:0];

    // Marks cycles whose previous cycle was out of reset.
    always_ff @(posedge clk) armed <= rst_n;

    AST_ERR_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> rdata_o == '0); // R7
    AST_DISABLED_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        req_i && !ram_en_i |=> err_o); // R3
    AST_STANDBY_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        req_i && standby_i |=> err_o); // R10
    AST_OUT_OF_RANGE_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        req_i && (addr_i[ADDR_W-1:HI_LSB] != '0) |=> err_o); // R1
    AST_STOPPED_LOW_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        armed && req_i && $past(stop_i[0]) && !addr_i[SEL_BIT] |=> err_o); // R4
    AST_STOPPED_HIGH_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        armed && req_i && $past(stop_i[1]) && addr_i[SEL_BIT] |=> err_o); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !err_o && rdata_o == '0); // R11
    AST_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        req_i && we_i |=> rdata_o == '0); // R11
endmodule

bind ram_dual_bank ram_dual_bank_chk #(
    .ADDR_W   (ADDR_W),
    .BANK_WAW (BANK_WAW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ram_en_i  (ram_en_i),
    .stop_i    (stop_i),
    .standby_i (standby_i),
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .rdata_o   (rdata_o),
    .err_o     (err_o)
);

// File: tb/ram_dual_bank_tb.sv
// Bench for ram_dual_bank: behavioural reference model, compared every clock.
module ram_dual_bank_tb;
    localparam int AW  = 32;
    localparam int WAW = 3;
    localparam int D   = 1 << WAW;
    localparam logic [31:0] PZ = 32'hDEADBEEF;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ram_en_i;
    logic [1:0]  stop_i;
    logic        standby_i;
    logic        retain_i;
    logic        req_i;
    logic        we_i;
    logic [31:0] addr_i;
    logic [3:0]  be_i;
    logic [31:0] wdata_i;
    logic [31:0] rdata_o;
    logic        err_o;

    always #2 clk = ~clk;

    ram_dual_bank #(.ADDR_W(AW), .BANK_WAW(WAW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ram_en_i(ram_en_i), .stop_i(stop_i),
        .standby_i(standby_i), .retain_i(retain_i), .req_i(req_i),
        .we_i(we_i), .addr_i(addr_i), .be_i(be_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .err_o(err_o)
    );

    // Reference model state.
    logic [31:0] mm [2*D];
    bit          vv [2*D];
    bit [1:0]    m_stop;
    bit          m_sb;
    logic [31:0] e_rd;
    bit          e_err;
    int          vecs = 0;
    int          bad  = 0;
    string       tag  = "R5";
    bit          done = 1'b0;

    // Model one clock edge from the inputs present at that edge.
    task automatic model_edge();
        int bank, k;
        bit ok;
        logic [31:0] cur;
        if (!rst_n) begin
            for (int i = 0; i < 2*D; i++) vv[i] = 1'b0;
            m_stop = '0; m_sb = 1'b0; e_rd = '0; e_err = 1'b0;
            return;
        end
        if (standby_i && !m_sb) begin
            for (int i = D; i < 2*D; i++) vv[i] = 1'b0;
            if (!retain_i) for (int i = 0; i < D; i++) vv[i] = 1'b0;
        end
        bank = int'(addr_i[WAW+2]);
        k    = bank * D + int'(addr_i[WAW+1:2]);
        ok   = req_i && ram_en_i && !standby_i && ((addr_i >> (WAW+3)) == 0)
               && !m_stop[bank];
        e_err = req_i && !ok;
        e_rd  = '0;
        if (ok) begin
            cur = vv[k] ? mm[k] : PZ;
            if (we_i) begin
                for (int b = 0; b < 4; b++) if (be_i[b]) cur[8*b +: 8] = wdata_i[8*b +: 8];
                mm[k] = cur;
                vv[k] = 1'b1;
            end else begin
                e_rd = cur;
            end
        end
        m_stop = stop_i;
        m_sb   = standby_i;
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        vecs++;
        if (rdata_o !== e_rd || err_o !== e_err) begin
            bad++;
            $display("FAIL %s rdata=%h exp=%h err=%b exp=%b", tag, rdata_o, e_rd, err_o, e_err);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) cyc();
    endtask

    task automatic acc(input bit w, input logic [31:0] a, input logic [3:0] be, input logic [31:0] d);
        req_i = 1'b1; we_i = w; addr_i = a; be_i = be; wdata_i = d;
        cyc();
        req_i = 1'b0; we_i = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a);
        acc(1'b0, a, 4'h0, 32'h0);
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        acc(1'b1, a, 4'hF, d);
    endtask

    // Watchdog: a hang counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL R2 watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ram_en_i = 1'b1; stop_i = '0; standby_i = 1'b0; retain_i = 1'b0;
        req_i = 1'b0; we_i = 1'b0; addr_i = '0; be_i = '0; wdata_i = '0;
        // R5: reset state, then unwritten words read poison (R9)
        tag = "R5"; idle(3);
        rst_n = 1'b1;
        rd(32'h0); rd(32'h20 + 32'hC); idle(1);
        // R2: write then read in the next cycle
        tag = "R2"; wr(32'h0, 32'h11111111); rd(32'h0); wr(32'h1C, 32'h7E7E7E7E); rd(32'h1C);
        // R1: bank select bit 5, aliasing low bits, out-of-range bit 6 and up
        tag = "R1"; wr(32'h24, 32'hA5A5A5A5); rd(32'h4); rd(32'h24); rd(32'h27);
        rd(32'h40); rd(32'h8000_0000); rd(32'h3C);
        // R8: byte strobe lanes
        tag = "R8"; wr(32'h8, 32'h01020304); acc(1'b1, 32'h8, 4'b0101, 32'hAABBCCDD); rd(32'h8);
        acc(1'b1, 32'h8, 4'b1000, 32'hEE000000); rd(32'h8);
        // R9: partial write into a poisoned word
        tag = "R9"; acc(1'b1, 32'hC, 4'b0010, 32'h00007700); rd(32'hC); rd(32'h10);
        // R7: failing write changes nothing
        tag = "R7"; wr(32'h48, 32'h12345678); rd(32'h8); acc(1'b1, 32'h40, 4'hF, 32'h0); rd(32'h0);
        // R3: global enable off
        tag = "R3"; ram_en_i = 1'b0; wr(32'h0, 32'hFFFFFFFF); rd(32'h0); rd(32'h24);
        ram_en_i = 1'b1; rd(32'h0); rd(32'h24);
        // R4: stop low bank, high bank still served, contents kept
        tag = "R4"; stop_i = 2'b01; idle(1); rd(32'h0); wr(32'h0, 32'h0BAD0BAD); rd(32'h24);
        stop_i = 2'b00; idle(1); rd(32'h0);
        stop_i = 2'b10; idle(1); rd(32'h24); rd(32'h0); stop_i = 2'b00; idle(1); rd(32'h24);
        // R6: stop rising with a request: served, next request blocked
        tag = "R6"; stop_i = 2'b10; rd(32'h24); rd(32'h24);
        stop_i = 2'b00; wr(32'h28, 32'h55AA55AA); idle(1);
        stop_i = 2'b01; wr(32'h14, 32'hC0FFEE00); wr(32'h14, 32'h0); stop_i = 2'b00; idle(1);
        rd(32'h14); rd(32'h28);
        // R10: standby with retention, then without
        tag = "R10"; retain_i = 1'b1; standby_i = 1'b1; rd(32'h0); idle(2);
        standby_i = 1'b0; retain_i = 1'b0; idle(1);
        rd(32'h0); rd(32'h8); rd(32'h24); rd(32'h28);
        wr(32'h24, 32'h24242424); rd(32'h24);
        standby_i = 1'b1; idle(2); wr(32'h4, 32'h1); standby_i = 1'b0; idle(1);
        rd(32'h0); rd(32'h14); rd(32'h24); rd(32'h4);
        // R11: idle cycles and write results are quiet
        tag = "R11"; idle(3); wr(32'h30, 32'h30303030); idle(1); rd(32'h30); idle(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end
endmodule